// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Enable Controller

This block gathers the three interrupt causes of a real-time clock: the periodic tick, the alarm match and the end of an update. Each cause arrives as a one-cycle event pulse. The block records each event in a flag of a status word, gates the flags with a software-written enable word, and drives an active-low interrupt request to the processor. Software can work in two ways. It can leave the enables off and poll the flags. It can also enable the sources and take the interrupt, then read the status word to find the cause and acknowledge it in one step.

The status read is double-latched. A read cycle is the run of consecutive clocks on which `stat_rd` is high. The status word does not change during that run. Flags that were set when the read began are cleared once the strobe drops. An event that arrives while the strobe is high is kept in a holding latch and posted to its flag after the read, so it cannot be lost in the clear.

The bit positions of the status and enable fields are parameters. The request path can be built as combinational or as registered.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: An event pulse sets its flag on the next clock edge whatever the state of its enable bit. With all enables at 0, `irq_n` stays 1 while the flags still read back as set.
- R2: With the default combinational request path, `irq_n` is 0 exactly when at least one source has both its flag and its enable bit at 1, and is 1 otherwise.
- R3: The status word carries these bits: periodic flag in bit 6, alarm flag in bit 5, update-ended flag in bit 4, and the request indicator in bit 7, which equals the inverse of `irq_n`. Bits 3 to 0 read as 0.
- R4: Writing a 1 to an enable bit whose flag is already set drives `irq_n` low on the cycle after the write edge.
- R5: After a status read cycle ends, on the first clock edge at which `stat_rd` is sampled low again, every flag that the read returned is cleared. The request indicator clears with them.
- R6: While `stat_rd` stays high for several cycles, `stat_rdata` does not change, even if events arrive during that time.
- R7: An event that arrives on any cycle on which `stat_rd` is high is not reported by that read. It appears in its flag from the cycle after the clearing edge, so the next read returns it.
- R8: While `rst_n` is low, all flags, held events and enable bits are 0 and `irq_n` is 1.
- R9: A write with `ctl_we` high loads enable bits 6 (periodic), 5 (alarm) and 4 (update-ended) from `ctl_wdata`. `ctl_rdata` returns those bits in the same positions, with every other bit 0, whatever was written to the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic | input | 1 | One-cycle periodic tick event |
| evt_alarm | input | 1 | One-cycle alarm match event |
| evt_update | input | 1 | One-cycle update-ended event |
| stat_rd | input | 1 | Status read strobe; one read cycle lasts as long as it stays high |
| stat_rdata | output | DATA_W | Status word: request indicator and flags |
| ctl_we | input | 1 | Enable word write strobe |
| ctl_wdata | input | DATA_W | Enable word write data |
| ctl_rdata | output | DATA_W | Enable word read-back |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is an event that arrives while a read is in progress. A wrong design that clears its flags at the end of the read would silently drop such an event. The bench raises each event on the same cycle as a one-clock read strobe, and also in the middle of a held multi-cycle read. It checks that the read in progress does not show the event and that the following read does. A full sweep of all enable patterns against all event patterns covers the polling and interrupt modes. The enable-after-flag case and reset in the middle of activity are tested separately.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

   // number of interrupt causes handled by the controller
   localparam int NUM_SRC = 3;

   // index of each cause inside the flag / enable vectors (LSB upward)
   typedef enum int unsigned {
      SRC_UPD = 0,
      SRC_ALM = 1,
      SRC_PER = 2
   } src_e;

endpackage

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic rd_act,
   input  logic rd_end,
   output logic flag,
   output logic held
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         held <= 1'b0;
      end else if (rd_act) begin
         // status frozen; park new events in the second latch
         held <= held | evt;
      end else if (rd_end) begin
         // read finished: drop the returned flag, post parked events
         flag <= held | evt;
         held <= 1'b0;
      end else begin
         flag <= flag | evt;
      end
   end

   AST_EVT_SETS:   assert property (@(posedge clk) disable iff (!rst_n)
                      (evt && !rd_act && !rd_end) |=> flag);            // R1
   AST_FLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                      rd_act |=> $stable(flag));                        // R6
   AST_EVT_HELD:   assert property (@(posedge clk) disable iff (!rst_n)
                      (rd_act && evt) |=> held);                        // R7
   AST_POSTED:     assert property (@(posedge clk) disable iff (!rst_n)
                      (rd_end && held) |=> flag);                       // R7

endmodule

// File: rtl/rtc_irq_req.sv
module rtc_irq_req #(
   parameter int NUM_SRC        = 3,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] flags,
   input  logic [NUM_SRC-1:0] en,
   output logic               irq_act
);

   logic any_hit;
   assign any_hit = |(flags & en);

   generate
      if (IRQ_REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_hit;
         end
         assign irq_act = irq_q;
      end else begin : g_comb
         assign irq_act = any_hit;
      end
   endgenerate

endmodule

// File: rtl/rtc_irq_stat_fmt.sv
module rtc_irq_stat_fmt #(
   parameter int DATA_W   = 8,
   parameter int FLAG_LSB = 4,
   parameter int NUM_SRC  = 3
) (
   input  logic [NUM_SRC-1:0] flags,
   input  logic               irqf,
   input  logic [NUM_SRC-1:0] en,
   output logic [DATA_W-1:0]  stat_word,
   output logic [DATA_W-1:0]  ctl_word
);

   localparam int IRQF_BIT = DATA_W - 1;
   localparam int FLAG_END = FLAG_LSB + NUM_SRC;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == IRQF_BIT) begin : g_irqf
            assign stat_word[b] = irqf;
            assign ctl_word[b]  = 1'b0;
         end else if (b >= FLAG_LSB && b < FLAG_END) begin : g_field
            assign stat_word[b] = flags[b-FLAG_LSB];
            assign ctl_word[b]  = en[b-FLAG_LSB];
         end else begin : g_zero
            assign stat_word[b] = 1'b0;
            assign ctl_word[b]  = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int FLAG_LSB       = 4,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_periodic,
   input  logic              evt_alarm,
   input  logic              evt_update,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] stat_rdata,
   input  logic              ctl_we,
   input  logic [DATA_W-1:0] ctl_wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   output logic              irq_n
);

   localparam int IRQF_BIT = DATA_W - 1;
   localparam int FLAG_MSB = FLAG_LSB + NUM_SRC - 1;

   // elaboration-time parameter checks
   generate
      if (FLAG_MSB >= IRQF_BIT) begin : g_bad_field
         $error("flag field overlaps the request indicator bit");
      end
      if (FLAG_LSB < 0) begin : g_bad_lsb
         $error("FLAG_LSB must not be negative");
      end
   endgenerate

   logic [NUM_SRC-1:0] evt_vec;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] held;
   logic [NUM_SRC-1:0] en_q;
   logic               rd_q;
   logic               rd_end;
   logic               irq_act;
   logic               unused_wdata;

   assign evt_vec[int'(SRC_UPD)] = evt_update;
   assign evt_vec[int'(SRC_ALM)] = evt_alarm;
   assign evt_vec[int'(SRC_PER)] = evt_periodic;

   assign unused_wdata = ^ctl_wdata;

   // read-cycle tracking: the clear happens on the first edge after the strobe drops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= stat_rd;
   end
   assign rd_end = rd_q & ~stat_rd;

   // enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (ctl_we) en_q <= ctl_wdata[FLAG_MSB:FLAG_LSB];
   end

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         rtc_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_vec[i]),
            .rd_act (stat_rd),
            .rd_end (rd_end),
            .flag   (flags[i]),
            .held   (held[i])
         );
      end
   endgenerate

   rtc_irq_req #(
      .NUM_SRC        (NUM_SRC),
      .IRQ_REGISTERED (IRQ_REGISTERED)
   ) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flags),
      .en      (en_q),
      .irq_act (irq_act)
   );

   assign irq_n = ~irq_act;

   rtc_irq_stat_fmt #(
      .DATA_W   (DATA_W),
      .FLAG_LSB (FLAG_LSB),
      .NUM_SRC  (NUM_SRC)
   ) u_fmt (
      .flags     (flags),
      .irqf      (irq_act),
      .en        (en_q),
      .stat_word (stat_rdata),
      .ctl_word  (ctl_rdata)
   );

   AST_IRQF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                      stat_rdata[IRQF_BIT] == ~irq_n);                   // R3

   generate
      if (!IRQ_REGISTERED) begin : g_en_chk
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
            AST_EN_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
                             (ctl_we && ctl_wdata[FLAG_LSB+i] && stat_rdata[FLAG_LSB+i]
                              && !stat_rd && !rd_end) |=> !irq_n);       // R4
         end
      end
   endgenerate

endmodule

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_periodic = 1'b0;
   logic       evt_alarm = 1'b0;
   logic       evt_update = 1'b0;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_rdata;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       irq_n;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   rtc_irq_ctrl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_periodic (evt_periodic),
      .evt_alarm    (evt_alarm),
      .evt_update   (evt_update),
      .stat_rd      (stat_rd),
      .stat_rdata   (stat_rdata),
      .ctl_we       (ctl_we),
      .ctl_wdata    (ctl_wdata),
      .ctl_rdata    (ctl_rdata),
      .irq_n        (irq_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // ev bits: [2] periodic, [1] alarm, [0] update-ended
   task automatic set_evt(input logic [2:0] ev);
      {evt_periodic, evt_alarm, evt_update} = ev;
   endtask

   task automatic pulse(input logic [2:0] ev);
      @(negedge clk); set_evt(ev);
      @(negedge clk); set_evt(3'b000);
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
      @(negedge clk); ctl_we = 1'b0; ctl_wdata = 8'h00;
   endtask

   // one-clock read; ev injected on the read cycle; returns after the clear edge
   task automatic rd_stat(input logic [2:0] ev, output logic [7:0] d);
      @(negedge clk); stat_rd = 1'b1; set_evt(ev);
      #1 d = stat_rdata;
      @(negedge clk); stat_rd = 1'b0; set_evt(3'b000);
      @(negedge clk);
   endtask

   function automatic logic [7:0] stat_exp(input logic [2:0] fl, input logic [2:0] en);
      return {|(fl & en), fl, 4'b0000};
   endfunction

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 irq_n in reset", {7'b0, irq_n}, 8'h01);
      check("R8 status in reset", stat_rdata, 8'h00);
      check("R8 enables in reset", ctl_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep every enable pattern against every event pattern
      for (int en = 0; en < 8; en++) begin
         for (int s = 0; s < 8; s++) begin
            wr_ctl({1'b1, en[2:0], 4'hF});
            check("R9 enable read-back", ctl_rdata, {1'b0, en[2:0], 4'h0});
            pulse(s[2:0]);
            check(en == 0 ? "R1 polling irq_n" : "R2 irq_n level",
                  {7'b0, irq_n}, {7'b0, ~|(en[2:0] & s[2:0])});
            rd_stat(3'b000, d);
            check(en == 0 ? "R1 flags with enables off" : "R3 status layout",
                  d, stat_exp(s[2:0], en[2:0]));
            check("R5 irq_n after read", {7'b0, irq_n}, 8'h01);
            check("R5 status cleared", stat_rdata, 8'h00);
         end
      end

      // R4: flag set first, enable written later
      wr_ctl(8'h00);
      pulse(3'b010);
      check("R4 irq_n before enable", {7'b0, irq_n}, 8'h01);
      wr_ctl(8'h20);
      check("R4 irq_n after enable", {7'b0, irq_n}, 8'h00);
      rd_stat(3'b000, d);
      check("R4 status", d, 8'hA0);

      // R7: event on the same cycle as a one-clock read strobe
      wr_ctl(8'h00);
      for (int i = 0; i < 3; i++) begin
         rd_stat(3'b001 << i, d);
         check("R7 read misses same-cycle event", d, 8'h00);
         rd_stat(3'b000, d);
         check("R7 next read shows event", d, {1'b0, 3'b001 << i, 4'h0});
      end
      pulse(3'b001);
      rd_stat(3'b010, d);
      check("R7 read returns old flag only", d, 8'h10);
      rd_stat(3'b000, d);
      check("R7 held alarm posted", d, 8'h20);

      // R6: held multi-cycle read with an event in the middle
      wr_ctl(8'h40);
      pulse(3'b100);
      @(negedge clk); stat_rd = 1'b1;
      #1 check("R6 read cycle 1", stat_rdata, 8'hC0);
      @(negedge clk); set_evt(3'b010);
      #1 check("R6 read cycle 2", stat_rdata, 8'hC0);
      @(negedge clk); set_evt(3'b000);
      #1 check("R6 read cycle 3", stat_rdata, 8'hC0);
      @(negedge clk); stat_rd = 1'b0;
      @(negedge clk);
      check("R5 irq released after long read", {7'b0, irq_n}, 8'h01);
      rd_stat(3'b000, d);
      check("R7 event from long read", d, 8'h20);

      // R8: reset in the middle of activity
      wr_ctl(8'h70);
      pulse(3'b111);
      check("R2 all sources", {7'b0, irq_n}, 8'h00);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R8 irq_n after reset", {7'b0, irq_n}, 8'h01);
      check("R8 flags after reset", stat_rdata, 8'h00);
      check("R8 enables after reset", ctl_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule